// File: doc/BRIEF.md
# Cycle-Steal Display Memory Arbiter

This block lets a host processor and a display refresh engine share one single-port display memory. Time is cut into basic cycles of two internal clocks. The first clock of each cycle is kept for a host access. The second clock always fetches a display word. The memory array itself and the formatting of display data for the panel lie outside the block.

While the screen is being drawn, the block is in cycle-steal mode. A host access drives WAIT low as soon as the chip select and a strobe overlap. WAIT returns high on a rising edge of the host clock once the access has been done in a host slot. During the horizontal sync term, stealing continues for a guard of a programmable number of characters. After the guard the block leaves cycle-steal mode and accesses complete with no WAIT. A host request crosses into the internal clock domain as a toggle through a two-flop synchronizer. The completion comes back the same way into the host clock domain.

Top module: `vram_steal_arbiter`

## Requirements
- R1: After reset, internal clocks alternate between a host slot and a display slot, starting with a host slot. Every display slot issues a read at `disp_addr`, and `disp_valid` is high in the following clock with the word on `disp_data`. A host memory operation is only issued in a host slot, so `disp_valid` is low in the clock after any host write.
- R2: While `steal_active` is set and the host is idle, WAIT (`host_wait_n`) goes low without a clock edge as soon as `host_cs_n` is low together with any of `host_rd_n`, `host_lwr_n` or `host_hwr_n`.
- R3: A waited access releases WAIT on a rising edge of `hclk` within 12 host clocks of the strobe falling.
- R4: On a host read, `host_rdata` holds the addressed word at the moment WAIT returns high and does not change at that edge.
- R5: With `disp_term` low, `hs_term` high and `hs_char` >= `hold_chars`, a host access never drives WAIT low and still performs its read or write.
- R6: With `hs_term` high and `hs_char` < `hold_chars`, cycle stealing stays active and WAIT is used. With `hold_chars` = 0 the guard is empty.
- R7: `steal_active` equals `disp_term | (hs_term & (hs_char < hold_chars))` sampled one internal clock earlier, and is 0 in reset.
- R8: After WAIT has been released, strobes that are still held low cause no new WAIT and no second memory operation.
- R9: `host_lwr_n` low writes the lower byte (`mem_we[0]`), `host_hwr_n` low writes the upper byte (`mem_we[1]`), and both low write the whole word. A byte that is not strobed keeps its old contents.
- R10: Each host access issues exactly one memory operation, and at most one request is pending at a time.
- R11: In reset, `host_wait_n` is 1 and `mem_en`, `mem_we`, `disp_valid` and `steal_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock (basic-cycle time base) |
| hclk | input | 1 | Host bus clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both domains |
| host_cs_n | input | 1 | Memory chip select from host, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_lwr_n | input | 1 | Lower-byte write strobe, active low |
| host_hwr_n | input | 1 | Upper-byte write strobe, active low |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data |
| host_wait_n | output | 1 | WAIT to host, low stretches the access |
| disp_term | input | 1 | Screen is being drawn |
| hs_term | input | 1 | Horizontal sync term in progress |
| hs_char | input | CW | Characters elapsed in the current sync term |
| hold_chars | input | CW | Guard length in characters during which stealing continues |
| steal_active | output | 1 | Status: cycle-steal mode in force |
| disp_addr | input | AW | Display fetch address |
| disp_valid | output | 1 | Display word valid on disp_data |
| disp_data | output | DW | Display word |
| mem_en | output | 1 | Memory enable |
| mem_we | output | DW/8 | Memory byte write enables |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one clock after mem_en |

## Verification
A lost or doubled request toggle shows at the ports as WAIT that never rises, which trips the release bound within 12 host clocks, or as a second write of the same access in the write count. A slot counter that is stuck or off by one shows within two internal clocks, as `disp_valid` high in two clocks in a row or right after a host write. A wrong steal decision shows one clock later on `steal_active`, and on the next access as WAIT missing in the guard or present in the free window. A read-data register loaded late shows as a stale `host_rdata` at the WAIT release edge.

// File: rtl/vsa_pkg.sv
// Shared types for the cycle-steal display memory arbiter.
package vsa_pkg;

    // Host-side access tracker states.
    typedef enum logic [1:0] {
        H_IDLE = 2'd0,   // no access in progress
        H_BUSY = 2'd1,   // request issued, waiting for completion
        H_DONE = 2'd2    // completed, waiting for host to release strobes
    } host_state_e;

    // Position inside the two-clock basic cycle.
    typedef enum logic {
        SLOT_HOST = 1'b0,
        SLOT_DISP = 1'b1
    } slot_e;

endpackage

// File: rtl/vsa_sync.sv
// Multi-stage synchronizer for a bus of independent level signals.
// Assumes each bit is a slow level or toggle that is held long enough
// to be seen; no multi-bit coherency is provided.
module vsa_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    // Remaining stages settle metastability.
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/vsa_host_port.sv
// Host clock side of the arbiter. Detects an access, drives WAIT,
// captures the request and flips a toggle towards the internal domain,
// then waits for the completion toggle. Assumes the host holds address,
// data and strobes stable until WAIT is high again (or, with no WAIT,
// long enough for the access to finish) and releases strobes between
// accesses.
module vsa_host_port
    import vsa_pkg::*;
#(
    parameter int AW     = 13,
    parameter int DW     = 16,
    parameter int STAGES = 2
) (
    input  logic            hclk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            lwr_n,
    input  logic            hwr_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            ack_tgl,
    input  logic            steal,
    output logic            wait_n,
    output logic            access,
    output logic            req_tgl,
    output logic            req_rd,
    output logic [DW/8-1:0] req_we,
    output logic [AW-1:0]   req_addr,
    output logic [DW-1:0]   req_wdata
);
    localparam int BW = DW / 8;

    host_state_e   state;
    logic          waited;
    logic          ack_seen;
    logic          ack_s;
    logic          steal_h;
    logic          done;
    logic [BW-1:0] we_now;

    // Bring completion toggle and steal mode into the host clock domain.
    vsa_sync #(.W(2), .STAGES(STAGES)) u_sync (
        .clk   (hclk),
        .rst_n (rst_n),
        .d     ({ack_tgl, steal}),
        .q     ({ack_s, steal_h})
    );

    // Overlap of chip select with any strobe starts an access.
    assign access = !cs_n && (!rd_n || !lwr_n || !hwr_n);
    assign done   = (ack_s != ack_seen);

    // Byte enables: lower half of the bytes from the low strobe, upper half from the high one.
    for (genvar g = 0; g < BW; g++) begin : g_be
        if (g < BW / 2) begin : g_lo
            assign we_now[g] = !lwr_n;
        end else begin : g_hi
            assign we_now[g] = !hwr_n;
        end
    end

    // Access tracker and request capture.
    always_ff @(posedge hclk) begin
        if (!rst_n) begin
            state     <= H_IDLE;
            waited    <= 1'b0;
            ack_seen  <= 1'b0;
            req_tgl   <= 1'b0;
            req_rd    <= 1'b0;
            req_we    <= '0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            case (state)
                H_IDLE: begin
                    if (access) begin
                        state     <= H_BUSY;
                        waited    <= steal_h;
                        req_tgl   <= ~req_tgl;
                        req_rd    <= !rd_n;
                        req_we    <= rd_n ? we_now : '0;
                        req_addr  <= addr;
                        req_wdata <= wdata;
                    end
                end
                H_BUSY: begin
                    if (done) begin
                        ack_seen <= ack_s;
                        state    <= H_DONE;
                    end
                end
                H_DONE: begin
                    if (!access) state <= H_IDLE;
                end
                default: state <= H_IDLE;
            endcase
        end
    end

    // WAIT: falls combinationally on a new access in steal mode, held until completion.
    always_comb begin
        case (state)
            H_IDLE:  wait_n = !(access && steal_h);
            H_BUSY:  wait_n = !waited;
            default: wait_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/vsa_slot_engine.sv
// Internal clock side. Runs the two-clock basic cycle: the host slot
// serves at most one pending host request, the display slot always
// reads the display address. Also decides cycle-steal mode from the
// timing inputs. Assumes the memory returns read data one clock after
// an enabled read and that request fields are stable while the request
// toggle is in flight.
module vsa_slot_engine
    import vsa_pkg::*;
#(
    parameter int AW     = 13,
    parameter int DW     = 16,
    parameter int CW     = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_tgl,
    input  logic            req_rd,
    input  logic [DW/8-1:0] req_we,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            disp_term,
    input  logic            hs_term,
    input  logic [CW-1:0]   hs_char,
    input  logic [CW-1:0]   hold_chars,
    input  logic [AW-1:0]   disp_addr,
    output logic            mem_en,
    output logic [DW/8-1:0] mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   rdata,
    output logic            ack_tgl,
    output logic            steal,
    output logic            disp_valid
);
    slot_e slot;
    logic  req_s;
    logic  req_seen;
    logic  pending;
    logic  rd_pend;
    logic  host_go;
    logic  disp_go;

    // Bring the request toggle into the internal clock domain.
    vsa_sync #(.W(1), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    assign host_go = pending && (slot == SLOT_HOST);
    assign disp_go = (slot == SLOT_DISP);

    // Basic cycle position.
    always_ff @(posedge clk) begin
        if (!rst_n) slot <= SLOT_HOST;
        else        slot <= (slot == SLOT_HOST) ? SLOT_DISP : SLOT_HOST;
    end

    // Single pending-request latch, set on a new toggle, cleared when served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            pending  <= 1'b0;
        end else if (req_s != req_seen) begin
            req_seen <= req_s;
            pending  <= 1'b1;
        end else if (host_go) begin
            pending  <= 1'b0;
        end
    end

    // Completion: writes finish in their slot, reads one clock later with data captured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            ack_tgl <= 1'b0;
            rdata   <= '0;
        end else begin
            rd_pend <= host_go && req_rd;
            if (host_go && !req_rd) begin
                ack_tgl <= ~ack_tgl;
            end else if (rd_pend) begin
                rdata   <= mem_rdata;
                ack_tgl <= ~ack_tgl;
            end
        end
    end

    // Display word is on the memory output the clock after a display slot.
    always_ff @(posedge clk) begin
        if (!rst_n) disp_valid <= 1'b0;
        else        disp_valid <= disp_go;
    end

    // Cycle-steal mode: drawing, or inside the guard at the start of sync.
    always_ff @(posedge clk) begin
        if (!rst_n) steal <= 1'b0;
        else        steal <= disp_term || (hs_term && (hs_char < hold_chars));
    end

    // Memory port multiplexing between the two slots.
    always_comb begin
        mem_en    = host_go || disp_go;
        mem_addr  = host_go ? req_addr : disp_addr;
        mem_we    = (host_go && !req_rd) ? req_we : '0;
        mem_wdata = req_wdata;
    end
endmodule

// File: rtl/vram_steal_arbiter.sv
// Top of the cycle-steal display memory arbiter: host clock port plus
// internal slot engine around one single-port memory interface.
// Assumes rst_n is held low across several edges of both clocks.
module vram_steal_arbiter #(
    parameter int AW     = 13,
    parameter int DW     = 16,
    parameter int CW     = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            hclk,
    input  logic            rst_n,
    input  logic            host_cs_n,
    input  logic            host_rd_n,
    input  logic            host_lwr_n,
    input  logic            host_hwr_n,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic            host_wait_n,
    input  logic            disp_term,
    input  logic            hs_term,
    input  logic [CW-1:0]   hs_char,
    input  logic [CW-1:0]   hold_chars,
    output logic            steal_active,
    input  logic [AW-1:0]   disp_addr,
    output logic            disp_valid,
    output logic [DW-1:0]   disp_data,
    output logic            mem_en,
    output logic [DW/8-1:0] mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    localparam int BW = DW / 8;

    logic          host_access;
    logic          req_tgl;
    logic          req_rd;
    logic [BW-1:0] req_we;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          ack_tgl;

    vsa_host_port #(.AW(AW), .DW(DW), .STAGES(STAGES)) u_host (
        .hclk      (hclk),
        .rst_n     (rst_n),
        .cs_n      (host_cs_n),
        .rd_n      (host_rd_n),
        .lwr_n     (host_lwr_n),
        .hwr_n     (host_hwr_n),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .ack_tgl   (ack_tgl),
        .steal     (steal_active),
        .wait_n    (host_wait_n),
        .access    (host_access),
        .req_tgl   (req_tgl),
        .req_rd    (req_rd),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata)
    );

    vsa_slot_engine #(.AW(AW), .DW(DW), .CW(CW), .STAGES(STAGES)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_tgl    (req_tgl),
        .req_rd     (req_rd),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .disp_term  (disp_term),
        .hs_term    (hs_term),
        .hs_char    (hs_char),
        .hold_chars (hold_chars),
        .disp_addr  (disp_addr),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .rdata      (host_rdata),
        .ack_tgl    (ack_tgl),
        .steal      (steal_active),
        .disp_valid (disp_valid)
    );

    // Display word comes straight from the memory output, qualified by disp_valid.
    assign disp_data = mem_rdata;
endmodule

// File: rtl/vsa_arbiter_checker.sv
// Protocol checker for the arbiter, attached to the top by bind.
module vsa_arbiter_checker #(
    parameter int DW = 16
) (
    input logic            clk,
    input logic            hclk,
    input logic            rst_n,
    input logic            host_wait_n,
    input logic            host_access,
    input logic [DW-1:0]   host_rdata,
    input logic [DW/8-1:0] mem_we,
    input logic            disp_valid,
    input logic            steal_active,
    input logic            disp_term,
    input logic            hs_term
);
    // R1: display valid never two clocks in a row (strict alternation).
    a_r1_disp_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid);

    // R1: a host write occupies a host slot, so no display word follows it.
    a_r1_write_in_host_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we) |=> !disp_valid);

    // R10: one request is one write; no back-to-back write clocks.
    a_r10_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we) |=> !(|mem_we));

    // R4: read data is already settled at the WAIT release edge.
    a_r4_rdata_settled: assert property (@(posedge hclk) disable iff (!rst_n)
        $rose(host_wait_n) |-> $stable(host_rdata));

    // R8: strobes still held after release produce no new WAIT.
    a_r8_no_rewait: assert property (@(posedge hclk) disable iff (!rst_n)
        ($rose(host_wait_n) && host_access) |=> host_wait_n);

    // R7: drawing forces steal mode on the next clock.
    a_r7_drawing_steals: assert property (@(posedge clk) disable iff (!rst_n)
        disp_term |=> steal_active);

    // R7: neither drawing nor sync means no stealing.
    a_r7_blank_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_term && !hs_term) |=> !steal_active);
endmodule

bind vram_steal_arbiter vsa_arbiter_checker #(.DW(DW)) u_chk (
    .clk          (clk),
    .hclk         (hclk),
    .rst_n        (rst_n),
    .host_wait_n  (host_wait_n),
    .host_access  (host_access),
    .host_rdata   (host_rdata),
    .mem_we       (mem_we),
    .disp_valid   (disp_valid),
    .steal_active (steal_active),
    .disp_term    (disp_term),
    .hs_term      (hs_term)
);

// File: tb/vram_steal_arbiter_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module vram_steal_arbiter_tb;
    localparam int AW = 13;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int REL_MAX = 12;

    logic          clk = 1'b0;
    logic          hclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_cs_n = 1'b1;
    logic          host_rd_n = 1'b1;
    logic          host_lwr_n = 1'b1;
    logic          host_hwr_n = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_wait_n;
    logic          disp_term = 1'b0;
    logic          hs_term = 1'b0;
    logic [CW-1:0] hs_char = '0;
    logic [CW-1:0] hold_chars = '0;
    logic          steal_active;
    logic [AW-1:0] disp_addr = '0;
    logic          disp_valid;
    logic [DW-1:0] disp_data;
    logic          mem_en;
    logic [1:0]    mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    int checks = 0;
    int fails = 0;
    int wr_count = 0;
    int clash = 0;
    logic [DW-1:0] exp_mem [64];
    logic [DW-1:0] ram [64];

    always #10 clk = ~clk;              // 50 MHz internal clock
    initial begin #3; forever #15 hclk = ~hclk; end

    vram_steal_arbiter #(.AW(AW), .DW(DW), .CW(CW)) u_dut (.*);

    // Memory model with one-clock read latency and byte enables.
    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= ram[mem_addr[5:0]];
            if (mem_we[0]) ram[mem_addr[5:0]][7:0]  <= mem_wdata[7:0];
            if (mem_we[1]) ram[mem_addr[5:0]][15:8] <= mem_wdata[15:8];
            if (|mem_we) wr_count++;
        end
    end

    // R1 monitor: after a host write clock, no display word in the next clock.
    logic prev_wr = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_wr && disp_valid) clash++;
        prev_wr = rst_n && (|mem_we);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_mode(input bit dt, input bit hs, input int ch, input int hold);
        @(negedge clk);
        disp_term = dt; hs_term = hs; hs_char = CW'(ch); hold_chars = CW'(hold);
        repeat (12) @(negedge hclk);
    endtask

    // One host access; reports early WAIT, release count, any WAIT low, data at end.
    task automatic host_op(input bit rd, input bit lo, input bit hi, input int a,
                           input logic [DW-1:0] d, input bit waited, input int hold_after,
                           output bit early_low, output int rel, output bit any_low,
                           output bit rewait, output logic [DW-1:0] rv);
        @(negedge hclk);
        host_addr = AW'(a); host_wdata = d; host_cs_n = 1'b0;
        host_rd_n = !rd; host_lwr_n = !(!rd && lo); host_hwr_n = !(!rd && hi);
        #1 early_low = !host_wait_n;
        any_low = early_low; rel = 0; rewait = 1'b0;
        if (waited) begin
            while (rel < 40) begin
                @(posedge hclk); #2; rel++;
                if (host_wait_n) break;
                any_low = 1'b1;
            end
        end else begin
            repeat (16) begin
                @(posedge hclk); #2;
                if (!host_wait_n) any_low = 1'b1;
            end
        end
        rv = host_rdata;
        repeat (hold_after) begin
            @(posedge hclk); #2;
            if (!host_wait_n) rewait = 1'b1;
        end
        @(negedge hclk);
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_lwr_n = 1'b1; host_hwr_n = 1'b1;
        repeat (4) @(negedge hclk);
        if (!rd) begin
            if (lo) exp_mem[a][7:0]  = d[7:0];
            if (hi) exp_mem[a][15:8] = d[15:8];
        end
    endtask

    task automatic t_reset;
        repeat (6) @(posedge hclk);
        #2;
        chk(host_wait_n === 1'b1 && mem_en === 1'b0 && mem_we === 2'b00 &&
            disp_valid === 1'b0 && steal_active === 1'b0, "R11", "reset outputs",
            {host_wait_n, mem_en, mem_we, disp_valid, steal_active}, 32'h20);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_steal_write_read;
        bit e, al, rw; int r, w0; logic [DW-1:0] v;
        set_mode(1, 0, 0, 1);
        chk(steal_active === 1'b1, "R7", "steal when drawing", steal_active, 1);
        w0 = wr_count;
        host_op(0, 1, 1, 3, 16'h1234, 1, 0, e, r, al, rw, v);
        chk(e, "R2", "WAIT low at strobe overlap", e, 1);
        chk(r <= REL_MAX && r >= 2, "R3", "write release clocks", r, REL_MAX);
        chk(wr_count - w0 == 1, "R10", "writes per access", wr_count - w0, 1);
        host_op(1, 0, 0, 3, '0, 1, 0, e, r, al, rw, v);
        chk(e, "R2", "WAIT low on read", e, 1);
        chk(r <= REL_MAX, "R3", "read release clocks", r, REL_MAX);
        chk(v === exp_mem[3], "R4", "read data at release", v, exp_mem[3]);
    endtask

    task automatic t_bytes;
        bit e, al, rw; int r; logic [DW-1:0] v;
        host_op(0, 1, 0, 3, 16'hFFEE, 1, 0, e, r, al, rw, v);
        host_op(1, 0, 0, 3, '0, 1, 0, e, r, al, rw, v);
        chk(v === 16'h12EE, "R9", "low strobe writes lower byte", v, 16'h12EE);
        host_op(0, 0, 1, 3, 16'h7700, 1, 0, e, r, al, rw, v);
        host_op(1, 0, 0, 3, '0, 1, 0, e, r, al, rw, v);
        chk(v === 16'h77EE, "R9", "high strobe writes upper byte", v, 16'h77EE);
    endtask

    task automatic t_free_window;
        bit e, al, rw; int r, w0; logic [DW-1:0] v;
        set_mode(0, 1, 5, 2);
        chk(steal_active === 1'b0, "R7", "free past guard", steal_active, 0);
        w0 = wr_count;
        host_op(0, 1, 1, 7, 16'h5A5A, 0, 0, e, r, al, rw, v);
        chk(!al, "R5", "no WAIT on free write", al, 0);
        chk(wr_count - w0 == 1, "R5", "free write performed", wr_count - w0, 1);
        host_op(1, 0, 0, 7, '0, 0, 0, e, r, al, rw, v);
        chk(!al && v === 16'h5A5A, "R5", "free read data", v, 16'h5A5A);
    endtask

    task automatic t_guard;
        bit e, al, rw; int r; logic [DW-1:0] v;
        set_mode(0, 1, 1, 2);
        chk(steal_active === 1'b1, "R7", "steal inside guard", steal_active, 1);
        host_op(0, 1, 1, 8, 16'hC3C3, 1, 0, e, r, al, rw, v);
        chk(e && r <= REL_MAX, "R6", "WAIT used inside guard", r, REL_MAX);
        set_mode(0, 1, 0, 0);
        chk(steal_active === 1'b0, "R6", "empty guard", steal_active, 0);
        set_mode(0, 0, 0, 2);
        chk(steal_active === 1'b0, "R7", "blank term free", steal_active, 0);
    endtask

    task automatic t_held;
        bit e, al, rw; int r, w0; logic [DW-1:0] v;
        set_mode(1, 0, 0, 1);
        w0 = wr_count;
        host_op(0, 1, 1, 9, 16'h0F0F, 1, 10, e, r, al, rw, v);
        chk(!rw, "R8", "no WAIT while strobes held", rw, 0);
        chk(wr_count - w0 == 1, "R8", "one write while held", wr_count - w0, 1);
        host_op(1, 0, 0, 9, '0, 1, 0, e, r, al, rw, v);
        chk(v === 16'h0F0F, "R10", "held write value", v, 16'h0F0F);
    endtask

    task automatic t_display;
        int pulses = 0; int bad = 0; bit last = 1'b0; int back2back = 0;
        @(negedge clk); disp_addr = AW'(3);
        repeat (3) @(negedge clk);
        repeat (20) begin
            @(negedge clk);
            if (disp_valid) begin
                pulses++;
                if (disp_data !== exp_mem[3]) bad++;
                if (last) back2back++;
            end
            last = disp_valid;
        end
        chk(pulses == 10, "R1", "display fetches in 20 clocks", pulses, 10);
        chk(bad == 0, "R1", "display word", bad, 0);
        chk(back2back == 0, "R1", "display strictly alternates", back2back, 0);
        chk(clash == 0, "R1", "host write in display slot", clash, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin ram[i] = '0; exp_mem[i] = '0; end
        t_reset();
        t_steal_write_read();
        t_bytes();
        t_free_window();
        t_guard();
        t_held();
        t_display();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2ms;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule